// File: doc/BRIEF.md
# Online logic implication checker

This block watches a bus of internal circuit signals while the device runs and flags any broken invariant among them. Every rule is fixed at elaboration time in a parameter table and is one of three kinds:

- a two-signal implication;
- a three-signal implication that applies only while a pivot signal holds a given value;
- a checking function, where one signal must equal AND, OR or XOR of two others, either operand optionally inverted.

Each rule drives its own combinational violation bit. A registered error flag reports whether any rule failed in the last valid sample. A sticky bit and a saturating counter keep the history of violations for later inspection.

The block is placed beside the logic it guards. Its sites input is wired to the chosen internal nets, and sample_vld marks the cycles in which those nets carry meaningful values. Each rule entry is a packed record holding:

- a kind code: 0 simple, 1 residual, 2 function, 3 disabled;
- an operator code: 0 AND, 1 OR, 2 XOR;
- two operand inversion bits;
- three expected values, one each for pivot, A and B;
- three 8-bit site indices, for pivot or result, A and B.

Top module: `impl_chk_top`

## Requirements
- R1: A simple rule (kind 0) "site A = val_a implies site B = val_b" raises its violation bit exactly when A equals val_a and B differs from val_b. This single check also covers the contrapositive, for example B=1 with A=1 for the rule A=1 implies B=0.
- R2: A residual rule (kind 1) raises its violation bit exactly when pivot P equals val_p, A equals val_a and B differs from val_b. When P differs from val_p, the rule never flags.
- R3: A function rule (kind 2) raises its violation bit exactly when the result site (the pivot index) differs from (A xor inv_a) OP (B xor inv_b), where op code 0 is AND, 1 is OR and 2 is XOR.
- R4: viol_vec bit i is the combinational violation of rule i. It depends only on sites and does not depend on sample_vld.
- R5: err_flag is 1 after a rising clock edge at which sample_vld was 1 and at least one viol_vec bit was set. After any other edge it is 0, so violations presented with sample_vld low are ignored.
- R6: err_sticky is set by a valid violation and holds until clr_hist is applied. When a valid violation and clr_hist occur in the same cycle, the sticky bit ends up set.
- R7: viol_cnt increments by one for each valid cycle that has any violation and saturates at 65535. clr_hist zeroes it; a valid violation in the clearing cycle leaves it at 1.
- R8: An asserted active-low rst_n clears err_flag, err_sticky and viol_cnt asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | Sites carry a valid sample this cycle |
| sites | input | SITE_W (19) | Monitored circuit signals |
| clr_hist | input | 1 | Synchronous clear of sticky bit and counter |
| viol_vec | output | NUM_RULES (7) | Combinational per-rule violation |
| err_flag | output | 1 | Registered any-violation flag |
| err_sticky | output | 1 | Violation seen since last clear |
| viol_cnt | output | CNT_W (16) | Saturating count of violating valid cycles |

## Verification
The bound checker watches the history logic on every cycle:

- the flag follows a valid violation and drops without a valid sample;
- the sticky bit holds until cleared;
- the counter never moves by more than one step and never wraps from its ceiling.

Whether each rule kind flags the right site combinations can only be shown by the bench. Its table of site patterns covers every kind, operator, inversion, the pivot gate and the contrapositive case. Directed scenarios cover the ignored invalid samples, a clear that coincides with a violation, saturation and reset.

// File: rtl/impl_chk_pkg.sv
package impl_chk_pkg;

  localparam int IDX_W     = 8;
  localparam int DEF_RULES = 7;

  typedef enum logic [1:0] {
    K_SIMPLE = 2'd0,
    K_RESID  = 2'd1,
    K_FUNC   = 2'd2,
    K_OFF    = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    OP_AND = 2'd0,
    OP_OR  = 2'd1,
    OP_XOR = 2'd2
  } op_e;

  // site_p is the pivot for residual rules and the result site for functions
  typedef struct packed {
    kind_e            kind;
    op_e              op;
    logic             inv_a;
    logic             inv_b;
    logic             val_p;
    logic             val_a;
    logic             val_b;
    logic [IDX_W-1:0] site_p;
    logic [IDX_W-1:0] site_a;
    logic [IDX_W-1:0] site_b;
  } rule_t;

  typedef rule_t [DEF_RULES-1:0] rule_tab_t;

  function automatic rule_t mk_rule(kind_e k, op_e o, logic ia, logic ib,
                                    logic vp, logic va, logic vb,
                                    int sp, int sa, int sb);
    rule_t r;
    r.kind   = k;
    r.op     = o;
    r.inv_a  = ia;
    r.inv_b  = ib;
    r.val_p  = vp;
    r.val_a  = va;
    r.val_b  = vb;
    r.site_p = IDX_W'(sp);
    r.site_a = IDX_W'(sa);
    r.site_b = IDX_W'(sb);
    return r;
  endfunction

  // Example table used when no table is supplied
  function automatic rule_tab_t default_rules();
    rule_tab_t t;
    t[0] = mk_rule(K_SIMPLE, OP_AND, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0,  0,  2,  5);
    t[1] = mk_rule(K_SIMPLE, OP_AND, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,  0,  0,  1);
    t[2] = mk_rule(K_RESID,  OP_AND, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1,  3,  4,  6);
    t[3] = mk_rule(K_RESID,  OP_AND, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0,  7,  8,  9);
    t[4] = mk_rule(K_FUNC,   OP_AND, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 12, 10, 11);
    t[5] = mk_rule(K_FUNC,   OP_OR,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 18, 16, 17);
    t[6] = mk_rule(K_FUNC,   OP_XOR, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 15, 13, 14);
    return t;
  endfunction

endpackage

// File: rtl/impl_chk_rule.sv
module impl_chk_rule
  import impl_chk_pkg::*;
#(
  parameter rule_t RULE = '0
) (
  input  logic bit_p,
  input  logic bit_a,
  input  logic bit_b,
  output logic viol
);

  logic unused_bits;

  generate
    if (RULE.kind == K_SIMPLE) begin : g_simple
      assign viol        = (bit_a == RULE.val_a) && (bit_b != RULE.val_b);
      assign unused_bits = bit_p;
    end else if (RULE.kind == K_RESID) begin : g_resid
      assign viol        = (bit_p == RULE.val_p) && (bit_a == RULE.val_a) &&
                           (bit_b != RULE.val_b);
      assign unused_bits = 1'b0;
    end else if (RULE.kind == K_FUNC) begin : g_func
      logic opa;
      logic opb;
      logic fn;
      assign opa = bit_a ^ RULE.inv_a;
      assign opb = bit_b ^ RULE.inv_b;
      always_comb begin
        case (RULE.op)
          OP_OR:   fn = opa | opb;
          OP_XOR:  fn = opa ^ opb;
          default: fn = opa & opb;
        endcase
      end
      assign viol        = (bit_p != fn);
      assign unused_bits = 1'b0;
    end else begin : g_off
      assign viol        = 1'b0;
      assign unused_bits = ^{bit_p, bit_a, bit_b};
    end
  endgenerate

endmodule

// File: rtl/impl_chk_hist.sv
module impl_chk_hist #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_vld,
  input  logic             any_viol,
  input  logic             clr_hist,
  output logic             err_flag,
  output logic             err_sticky,
  output logic [CNT_W-1:0] viol_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             hit;
  logic             flag_nxt;
  logic             sticky_nxt;
  logic [CNT_W-1:0] cnt_base;
  logic [CNT_W-1:0] cnt_nxt;

  assign hit = sample_vld & any_viol;

  always_comb begin
    flag_nxt   = hit;
    sticky_nxt = hit | (err_sticky & ~clr_hist);
    cnt_base   = clr_hist ? '0 : viol_cnt;
    cnt_nxt    = cnt_base;
    if (hit && (cnt_base != CNT_MAX)) begin
      cnt_nxt = cnt_base + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag   <= 1'b0;
      err_sticky <= 1'b0;
      viol_cnt   <= '0;
    end else begin
      err_flag   <= flag_nxt;
      err_sticky <= sticky_nxt;
      viol_cnt   <= cnt_nxt;
    end
  end

endmodule

// File: rtl/impl_chk_top.sv
module impl_chk_top
  import impl_chk_pkg::*;
#(
  parameter int                        SITE_W    = 19,
  parameter int                        NUM_RULES = DEF_RULES,
  parameter int                        CNT_W     = 16,
  parameter rule_t [NUM_RULES-1:0]     RULES     = default_rules()
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_vld,
  input  logic [SITE_W-1:0]    sites,
  input  logic                 clr_hist,
  output logic [NUM_RULES-1:0] viol_vec,
  output logic                 err_flag,
  output logic                 err_sticky,
  output logic [CNT_W-1:0]     viol_cnt
);

  logic any_viol;

  for (genvar i = 0; i < NUM_RULES; i++) begin : g_rule
    localparam int PI = int'(RULES[i].site_p);
    localparam int AI = int'(RULES[i].site_a);
    localparam int BI = int'(RULES[i].site_b);

    impl_chk_rule #(
      .RULE (RULES[i])
    ) u_rule (
      .bit_p (sites[PI]),
      .bit_a (sites[AI]),
      .bit_b (sites[BI]),
      .viol  (viol_vec[i])
    );
  end

  assign any_viol = |viol_vec;

  impl_chk_hist #(
    .CNT_W (CNT_W)
  ) u_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_vld (sample_vld),
    .any_viol   (any_viol),
    .clr_hist   (clr_hist),
    .err_flag   (err_flag),
    .err_sticky (err_sticky),
    .viol_cnt   (viol_cnt)
  );

endmodule

// File: rtl/impl_chk_sva.sv
module impl_chk_sva #(
  parameter int NUM_RULES = 7,
  parameter int CNT_W     = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sample_vld,
  input logic                 clr_hist,
  input logic [NUM_RULES-1:0] viol_vec,
  input logic                 err_flag,
  input logic                 err_sticky,
  input logic [CNT_W-1:0]     viol_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  a_r5_flag_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && (viol_vec != '0)) |=> err_flag);

  a_r5_flag_drop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> !err_flag);

  a_r6_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !clr_hist) |=> err_sticky);

  a_r6_sticky_follows_flag: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> err_sticky);

  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ((viol_cnt == CNT_MAX) && !clr_hist) |=> (viol_cnt == CNT_MAX));

  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_hist |=> ((viol_cnt == $past(viol_cnt)) ||
                   (viol_cnt == $past(viol_cnt) + 1'b1)));

  a_r7_still_without_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_hist && !sample_vld) |=> $stable(viol_cnt));

endmodule

bind impl_chk_top impl_chk_sva #(
  .NUM_RULES (NUM_RULES),
  .CNT_W     (CNT_W)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_vld (sample_vld),
  .clr_hist   (clr_hist),
  .viol_vec   (viol_vec),
  .err_flag   (err_flag),
  .err_sticky (err_sticky),
  .viol_cnt   (viol_cnt)
);

// File: tb/impl_chk_top_tb.sv
module impl_chk_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SITE_W     = 19;
  localparam int NR         = 7;
  localparam int CNT_W      = 16;
  localparam int NVEC       = 21;
  localparam logic [SITE_W-1:0] BASE = 19'h40000; // site 18 high keeps rule 5 quiet

  // {extra site bits, expected viol_vec}
  localparam logic [SITE_W+NR-1:0] VEC [NVEC] = '{
    {19'h00000, 7'h00}, // R1 quiet
    {19'h00004, 7'h00}, // R1 s2=1 s5=0 satisfied
    {19'h00024, 7'h01}, // R1 s2=1 s5=1
    {19'h00002, 7'h02}, // R1 contrapositive s1=1 s0=0
    {19'h00003, 7'h00}, // R1 s0=1 s1=1
    {19'h00010, 7'h04}, // R2 pivot active, s6 wrong
    {19'h00018, 7'h00}, // R2 pivot off
    {19'h00050, 7'h00}, // R2 satisfied
    {19'h00380, 7'h08}, // R2 pivot=1 s8=1 s9=1
    {19'h00300, 7'h00}, // R2 pivot off
    {19'h00180, 7'h00}, // R2 satisfied
    {19'h00800, 7'h10}, // R3 ~s10&s11=1, s12=0
    {19'h01800, 7'h00}, // R3 AND satisfied
    {19'h00C00, 7'h00}, // R3 inverted operand gives 0
    {19'h01400, 7'h10}, // R3 result high wrongly
    {19'h20000, 7'h20}, // R3 OR with inverted b gives 0, s18=1
    {19'h30000, 7'h00}, // R3 OR satisfied
    {19'h02000, 7'h40}, // R3 XOR=1 s15=0
    {19'h06000, 7'h00}, // R3 XOR=0
    {19'h0E000, 7'h40}, // R3 XOR=0 s15=1
    {19'h02026, 7'h43}  // R4 several rules at once
  };

  logic              clk;
  logic              rst_n;
  logic              sample_vld;
  logic [SITE_W-1:0] sites;
  logic              clr_hist;
  logic [NR-1:0]     viol_vec;
  logic              err_flag;
  logic              err_sticky;
  logic [CNT_W-1:0]  viol_cnt;

  int checks;
  int errors;
  bit done;

  impl_chk_top u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_vld (sample_vld),
    .sites      (sites),
    .clr_hist   (clr_hist),
    .viol_vec   (viol_vec),
    .err_flag   (err_flag),
    .err_sticky (err_sticky),
    .viol_cnt   (viol_cnt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at falling edge, return 1 time unit after the next rising edge
  task automatic step(logic vld, logic [SITE_W-1:0] s, logic clr);
    @(negedge clk);
    sample_vld = vld;
    sites      = s;
    clr_hist   = clr;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int exp_cnt;
    checks     = 0;
    errors     = 0;
    rst_n      = 1'b0;
    sample_vld = 1'b0;
    sites      = BASE;
    clr_hist   = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset flag", 32'(err_flag), 0);
    chk("R8 reset sticky", 32'(err_sticky), 0);
    chk("R8 reset count", 32'(viol_cnt), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk
    exp_cnt = 0;
    for (int i = 0; i < NVEC; i++) begin
      logic [SITE_W-1:0] s;
      logic [NR-1:0]     e;
      s = VEC[i][SITE_W+NR-1:NR] | BASE;
      e = VEC[i][NR-1:0];
      @(negedge clk);
      sample_vld = 1'b1;
      sites      = s;
      #1;
      chk("R1 R2 R3 viol_vec", 32'(viol_vec), 32'(e));
      @(posedge clk);
      #1;
      if (e != '0) exp_cnt++;
      chk("R5 err_flag", 32'(err_flag), 32'(e != '0));
      chk("R7 count", 32'(viol_cnt), 32'(exp_cnt));
    end
    chk("R6 sticky after table", 32'(err_sticky), 1);

    // R4: viol_vec ignores sample_vld; R5: invalid sample ignored
    step(1'b0, BASE | 19'h00024, 1'b0);
    chk("R4 viol without valid", 32'(viol_vec), 32'h01);
    chk("R5 flag ignores invalid", 32'(err_flag), 0);
    chk("R7 count ignores invalid", 32'(viol_cnt), 32'(exp_cnt));

    // R6/R7 clear without violation
    step(1'b1, BASE, 1'b1);
    chk("R6 sticky cleared", 32'(err_sticky), 0);
    chk("R7 count cleared", 32'(viol_cnt), 0);
    step(1'b1, BASE, 1'b0);
    chk("R6 sticky stays clear", 32'(err_sticky), 0);

    // R6/R7 clear coinciding with violation
    step(1'b1, BASE | 19'h00002, 1'b0);
    step(1'b1, BASE | 19'h00002, 1'b1);
    chk("R6 set wins over clear", 32'(err_sticky), 1);
    chk("R7 clear plus hit", 32'(viol_cnt), 1);
    step(1'b1, BASE, 1'b0);
    chk("R6 sticky holds", 32'(err_sticky), 1);
    chk("R5 flag drops", 32'(err_flag), 0);

    // R7 saturation
    @(negedge clk);
    sample_vld = 1'b1;
    sites      = BASE | 19'h00010;
    clr_hist   = 1'b0;
    repeat (65540) @(posedge clk);
    #1;
    chk("R7 saturated", 32'(viol_cnt), 32'hFFFF);

    // R8 asynchronous reset mid-run
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    chk("R8 async flag", 32'(err_flag), 0);
    chk("R8 async sticky", 32'(err_sticky), 0);
    chk("R8 async count", 32'(viol_cnt), 0);
    @(negedge clk);
    rst_n      = 1'b1;
    sample_vld = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule